// File: doc/BRIEF.md
# SPI Byte Queues with Interrupt Status

This unit sits between a processor register bus and the serial shift engine of an SPI host controller. It holds two byte queues of equal depth: one feeds the shift engine, and one collects bytes the shift engine has received. The processor pushes outgoing bytes with a bus write and pops incoming bytes with a bus read. It reads both fill levels from one status word, and it can flush either queue by setting a control bit.

Three events are latched into a sticky status register: the receive queue is nearly full, the transmit queue is nearly drained, and the shift engine has finished a transfer. Software clears a status bit by writing 1 to it. A threshold bit whose condition is still true when the write arrives stays set, so software can service a queue first and acknowledge it afterwards. An enable register with the same bit layout masks the status into a single level interrupt.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: Each queue holds up to DEPTH (default 64) bytes. A push into a full queue is dropped and leaves the count and the stored bytes unchanged.
- R2: Reading register 5 returns the level word. Bits 6:0 hold the receive count, bits 22:16 hold the transmit count, and every other bit is 0.
- R3: A bus write to register 1 pushes wdata[7:0] into the transmit queue. The shift engine sees the oldest byte on tx_byte and removes it with tx_take. tx_avail is high exactly when the transmit queue is not empty.
- R4: An rx_put strobe pushes rx_byte into the receive queue. A bus read of register 0 returns the oldest byte and pops it. A read while the queue is empty returns 0 and leaves the count at 0.
- R5: Writing register 2 with bit 8 set flushes the transmit queue, and with bit 9 set flushes the receive queue. The flush takes effect on the following clock, and the other queue is left untouched. Register 2 reads as 0.
- R6: Status bit 4 (register 4) becomes set when the receive count is at least 3/4 of DEPTH (48).
- R7: Status bit 12 becomes set when the transmit count is at most 1/4 of DEPTH (16).
- R8: Status bit 16 becomes set on an xfer_done pulse and stays set until software clears it.
- R9: Writing register 4 clears each status bit written as 1 and leaves bits written as 0 unchanged. A threshold bit whose condition still holds is set again at once.
- R10: Register 3 holds the interrupt enables at bits 4, 12 and 16 and reads back. irq is high exactly when some status bit and its enable bit are both set.
- R11: After reset both queues are empty, the enables are 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register index |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on register 0) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| irq | output | 1 | Level interrupt |
| tx_avail | output | 1 | Transmit queue not empty |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_take | input | 1 | Shift engine removes the transmit byte |
| rx_byte | input | 8 | Received byte from the shift engine |
| rx_put | input | 1 | Shift engine pushes rx_byte |
| xfer_done | input | 1 | Transfer-finished pulse |

## Verification
The hardest case to reach is a status clear that arrives while its threshold condition still holds, since the set and the clear must act on the same bit in the same clock. The stimulus produces it twice. The first time, it acknowledges the drain flag while the transmit queue holds only three bytes and expects the flag to remain set. The second time, it fills the transmit queue past its limit so the flag can actually clear, then flushes the queue and watches the flag return. The receive threshold is approached one byte at a time, so the step from 47 to 48 bytes is observed directly.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int DATA_W = 8;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_RXDATA   = 3'd0,
    REG_TXDATA   = 3'd1,
    REG_CTRL     = 3'd2,
    REG_IRQ_EN   = 3'd3,
    REG_IRQ_STAT = 3'd4,
    REG_LEVEL    = 3'd5
  } reg_sel_e;

  localparam int BIT_TX_FLUSH = 8;
  localparam int BIT_RX_FLUSH = 9;
  localparam int BIT_RX_HI    = 4;
  localparam int BIT_TX_LO    = 12;
  localparam int BIT_DONE     = 16;
  localparam int LVL_RX_LSB   = 0;
  localparam int LVL_TX_LSB   = 16;
  localparam int LVL_W        = 7;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, wr_ptr_n, rd_ptr, rd_ptr_n;
  logic [CW-1:0] count_n;
  logic          full, empty, push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    count_n  = count;
    if (flush) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      count_n  = '0;
    end else begin
      if (push_ok) wr_ptr_n = wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr_n = rd_ptr + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   count_n = count + CW'(1);
        2'b01:   count_n = count - CW'(1);
        default: count_n = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      count  <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  assign pop_data = empty ? '0 : mem[rd_ptr];

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_full_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> $stable(count));
  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !flush) |=> (count == '0));
  p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
endmodule

// File: rtl/irq_status.sv
module irq_status
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW    = $clog2(DEPTH) + 1,
  localparam int RX_HI = (DEPTH * 3) / 4,
  localparam int TX_LO = DEPTH / 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    rx_count,
  input  logic [CW-1:0]    tx_count,
  input  logic             done_pulse,
  input  logic             en_we,
  input  logic             stat_we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] enable,
  output logic [REG_W-1:0] status,
  output logic             irq
);
  localparam logic [REG_W-1:0] MASK =
    (REG_W'(1) << BIT_RX_HI) | (REG_W'(1) << BIT_TX_LO) | (REG_W'(1) << BIT_DONE);

  logic [REG_W-1:0] set_vec, clr_vec, status_n, enable_n;

  always_comb begin
    set_vec            = '0;
    set_vec[BIT_RX_HI] = (rx_count >= CW'(RX_HI));
    set_vec[BIT_TX_LO] = (tx_count <= CW'(TX_LO));
    set_vec[BIT_DONE]  = done_pulse;
    clr_vec            = stat_we ? wdata : '0;
    status_n           = ((status & ~clr_vec) | set_vec) & MASK;
    enable_n           = en_we ? (wdata & MASK) : enable;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= status_n;
      enable <= enable_n;
    end
  end

  assign irq = |(status & enable);

  p_rx_hi_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count >= CW'(RX_HI)) |=> status[BIT_RX_HI]);
  p_tx_lo_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= CW'(TX_LO)) |=> status[BIT_TX_LO]);
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status[BIT_DONE] && !(stat_we && wdata[BIT_DONE])) |=> status[BIT_DONE]);
  p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && wdata[BIT_DONE] && !done_pulse) |=> !status[BIT_DONE]);
  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq);
endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq,
  output logic              tx_avail,
  output logic [DATA_W-1:0] tx_byte,
  input  logic              tx_take,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_put,
  input  logic              xfer_done
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [CW-1:0]     tx_count, rx_count;
  logic [DATA_W-1:0] rx_head;
  logic [REG_W-1:0]  enable, status, level;
  logic              tx_flush_q, tx_flush_n, rx_flush_q, rx_flush_n;
  logic              tx_push, rx_pop, ctrl_we, en_we, stat_we;

  assign ctrl_we = bus_wr && (bus_addr == REG_CTRL);
  assign en_we   = bus_wr && (bus_addr == REG_IRQ_EN);
  assign stat_we = bus_wr && (bus_addr == REG_IRQ_STAT);
  assign tx_push = bus_wr && (bus_addr == REG_TXDATA);
  assign rx_pop  = bus_rd && (bus_addr == REG_RXDATA);

  assign tx_flush_n = ctrl_we && bus_wdata[BIT_TX_FLUSH];
  assign rx_flush_n = ctrl_we && bus_wdata[BIT_RX_FLUSH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_flush_q <= 1'b0;
      rx_flush_q <= 1'b0;
    end else begin
      tx_flush_q <= tx_flush_n;
      rx_flush_q <= rx_flush_n;
    end
  end

  byte_fifo #(.DEPTH(DEPTH), .W(DATA_W)) i_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush_q),
    .push(tx_push), .push_data(bus_wdata[DATA_W-1:0]),
    .pop(tx_take), .pop_data(tx_byte), .count(tx_count)
  );

  byte_fifo #(.DEPTH(DEPTH), .W(DATA_W)) i_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush_q),
    .push(rx_put), .push_data(rx_byte),
    .pop(rx_pop), .pop_data(rx_head), .count(rx_count)
  );

  irq_status #(.DEPTH(DEPTH)) i_irq_status (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
    .done_pulse(xfer_done), .en_we(en_we), .stat_we(stat_we),
    .wdata(bus_wdata), .enable(enable), .status(status), .irq(irq)
  );

  assign tx_avail = (tx_count != '0);

  always_comb begin
    level = '0;
    level[LVL_RX_LSB +: CW] = rx_count;
    level[LVL_TX_LSB +: CW] = tx_count;
  end

  always_comb begin
    case (bus_addr)
      REG_RXDATA:   bus_rdata = REG_W'(rx_head);
      REG_IRQ_EN:   bus_rdata = enable;
      REG_IRQ_STAT: bus_rdata = status;
      REG_LEVEL:    bus_rdata = level;
      default:      bus_rdata = '0;
    endcase
  end

  p_empty_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_count == '0) |-> (bus_rdata == '0));
  p_tx_avail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && tx_count == CW'(1) && !tx_push) |=> !tx_avail);
endmodule

// File: tb/test_spi_fifo_irq_unit.sv
module test_spi_fifo_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, tx_avail, tx_take = 1'b0, rx_put = 1'b0, xfer_done = 1'b0;
  logic [7:0]  tx_byte, rx_byte = '0;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_fifo_irq_unit i_spi_fifo_irq_unit (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .tx_avail(tx_avail), .tx_byte(tx_byte), .tx_take(tx_take),
    .rx_byte(rx_byte), .rx_put(rx_put), .xfer_done(xfer_done)
  );

  // op: 0 idle, 1 write, 2 read and compare
  localparam int NV = 12;
  localparam logic [36:0] VEC [NV] = '{
    {2'd1, 3'd1, 32'h0000_00A1},  // R3 push
    {2'd1, 3'd1, 32'h0000_00B2},
    {2'd1, 3'd1, 32'h0000_00C3},
    {2'd0, 3'd0, 32'h0},
    {2'd2, 3'd5, 32'h0003_0000},  // R2 tx count 3
    {2'd1, 3'd3, 32'h0001_1010},
    {2'd2, 3'd3, 32'h0001_1010},  // R10 enable readback
    {2'd2, 3'd4, 32'h0000_1000},  // R7 drain flag
    {2'd1, 3'd4, 32'h0000_1000},
    {2'd0, 3'd0, 32'h0},
    {2'd2, 3'd4, 32'h0000_1000},  // R9 flag re-set, condition holds
    {2'd2, 3'd2, 32'h0}           // R5 control reads 0
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [31:0] mask, logic [31:0] exp);
    bus_addr = a; bus_rd = 1'b1;
    #1 chk(req, bus_rdata & mask, exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rx_in(logic [7:0] b);
    rx_byte = b; rx_put = 1'b1;
    @(negedge clk);
    rx_put = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int bad;
    logic [7:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk("R11 irq", {31'b0, irq}, 32'h0);
    rd_chk("R11 level", 3'd5, 32'hFFFF_FFFF, 32'h0);
    rd_chk("R11 enable", 3'd3, 32'hFFFF_FFFF, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][36:35])
        2'd1: wr(VEC[i][34:32], VEC[i][31:0]);
        2'd2: rd_chk($sformatf("vector %0d (R2/R5/R7/R9/R10)", i),
                     VEC[i][34:32], 32'hFFFF_FFFF, VEC[i][31:0]);
        default: idle();
      endcase
    end
    chk("R10 irq on", {31'b0, irq}, 32'h1);

    // R3 serial side drains in order
    for (int i = 0; i < 3; i++) begin
      #1 got = tx_byte;
      chk("R3 tx order", {24'b0, got}, 32'(8'hA1 + 8'h11 * i));
      tx_take = 1'b1;
      @(negedge clk);
      tx_take = 1'b0;
    end
    chk("R3 tx_avail low", {31'b0, tx_avail}, 32'h0);

    // R1 overfill
    for (int i = 0; i < 70; i++) wr(3'd1, 32'(i));
    idle();
    rd_chk("R1 full level", 3'd5, 32'hFFFF_FFFF, 32'h0040_0000);
    #1 chk("R1 oldest kept", {24'b0, tx_byte}, 32'h0);
    tx_take = 1'b1; @(negedge clk); tx_take = 1'b0;
    idle();
    wr(3'd4, 32'h0000_1000);
    idle();
    rd_chk("R9 clear", 3'd4, 32'hFFFF_FFFF, 32'h0);
    chk("R10 irq off", {31'b0, irq}, 32'h0);

    // R5 tx flush
    wr(3'd2, 32'h0000_0100);
    idle(); idle();
    rd_chk("R5 tx flush", 3'd5, 32'hFFFF_FFFF, 32'h0);
    idle();
    rd_chk("R7 flag returns", 3'd4, 32'h0000_1000, 32'h0000_1000);

    // R6 receive threshold
    for (int i = 0; i < 47; i++) rx_in(8'(i));
    idle(); idle();
    rd_chk("R6 below 48", 3'd4, 32'h0000_0010, 32'h0);
    rx_in(8'd47);
    idle(); idle();
    rd_chk("R6 at 48", 3'd4, 32'h0000_0010, 32'h0000_0010);
    bad = 0;
    for (int i = 0; i < 48; i++) begin
      bus_addr = 3'd0; bus_rd = 1'b1;
      #1 if (bus_rdata !== 32'(i)) bad++;
      @(negedge clk);
      bus_rd = 1'b0;
    end
    chk("R4 rx order mismatches", 32'(bad), 32'h0);
    idle();
    rd_chk("R6 sticky", 3'd4, 32'h0000_0010, 32'h0000_0010);
    wr(3'd4, 32'h0000_0010);
    idle();
    rd_chk("R9 rx flag cleared", 3'd4, 32'h0000_0010, 32'h0);

    // R4 empty read
    rd_chk("R4 empty read", 3'd0, 32'hFFFF_FFFF, 32'h0);
    rd_chk("R4 count stays 0", 3'd5, 32'h0000_007F, 32'h0);

    // R5 rx flush leaves tx alone
    for (int i = 0; i < 5; i++) rx_in(8'hE0);
    wr(3'd1, 32'h11); wr(3'd1, 32'h22);
    wr(3'd2, 32'h0000_0200);
    idle(); idle();
    rd_chk("R5 rx flush", 3'd5, 32'hFFFF_FFFF, 32'h0002_0000);

    // R8 transfer done
    rd_chk("R8 before pulse", 3'd4, 32'h0001_0000, 32'h0);
    xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
    repeat (4) idle();
    rd_chk("R8 held", 3'd4, 32'h0001_0000, 32'h0001_0000);
    wr(3'd4, 32'h0001_0000);
    idle();
    rd_chk("R9 done cleared", 3'd4, 32'h0001_0000, 32'h0);

    // R10 masking
    wr(3'd3, 32'h0);
    idle();
    chk("R10 masked", {31'b0, irq}, 32'h0);
    wr(3'd3, 32'h0000_1000);
    idle();
    chk("R10 tx drain irq", {31'b0, irq}, 32'h1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule